// File: doc/BRIEF.md
# Transmit Slot Allocator with Completion Cookies

This block keeps the slot bookkeeping for a set of circular transmit rings, at most six. A client asks for room for one frame on a chosen ring. The block reserves two consecutive slots, one for the frame header and one for the payload. It answers with the header slot and a 16-bit cookie that names both the ring and that slot. The cookie travels with the frame. When the far side reports the frame as sent, it returns the cookie. The block decodes the cookie and confirms that the report names the oldest slot still in use on that ring. It then releases the slots.

Each ring stops accepting frames once fewer than two slots remain free. A `ring_stopped` level shows this to the client. After a completion on a stopped ring, a one-cycle `ring_wake` pulse tells the client that the ring accepts frames again. A zero cookie is never produced, because downstream logic uses zero to mark an empty status entry. Each ring also records the highest number of slots it has ever had in use, and a select input reads that value out.

Top module: `txs_slot_alloc`

## Requirements
- R1: After reset no ring is stopped, every response output and wake pulse is low, and every high-water mark reads 0.
- R2: An accepted allocation returns a cookie whose bits 15:12 hold 0xA plus the ring id (ring 0 gives 0xA, ring 5 gives 0xF) and whose bits 11:0 hold the header slot. The cookie is never zero.
- R3: Each accepted frame takes two slots in circular order: the header slot follows the last slot handed out and the payload slot follows it. A fresh ring starts at slot 0, and the slot after SLOTS-1 is 0. The response (`alloc_ack` with `alloc_slot` and `alloc_cookie`) appears in the cycle after the request.
- R4: When an accepted allocation leaves a ring with fewer than two free slots, that ring's `ring_stopped` goes high in the cycle after the request.
- R5: A request for a stopped ring, for a ring with fewer than two free slots, or for a ring id of NUM_RINGS or above is refused with `alloc_err` and leaves all ring state unchanged.
- R6: A completion whose slot differs from the ring's oldest used slot (current minus used plus one, taken modulo SLOTS) raises `cmp_order_err` and frees nothing.
- R7: An in-order completion raises `cmp_done`. It frees two slots (header and payload) when `cmp_last` is 1 and one slot when `cmp_last` is 0. A completion that would free more slots than are in use is treated as out of order.
- R8: An in-order completion on a stopped ring clears `ring_stopped` for that ring and pulses its `ring_wake` bit for exactly one cycle.
- R9: A completion cookie whose prefix names no configured ring (below 0xA, or 0xA plus NUM_RINGS and above), or whose slot field is SLOTS or more, raises `cmp_bad_cookie` and changes no state.
- R10: `hwm_level` shows the largest used-slot count the ring selected by `hwm_ring` has reached since reset. It reads 0 for an unconfigured id.
- R11: Rings are independent: allocations and completions on one ring do not change another ring's slots, counts or stop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request room for one frame |
| alloc_ring | input | 3 | Ring id of the request |
| alloc_ack | output | 1 | Request accepted (one cycle after request) |
| alloc_err | output | 1 | Request refused (one cycle after request) |
| alloc_slot | output | $clog2(SLOTS) | Header slot of the accepted frame |
| alloc_cookie | output | 16 | Cookie of the accepted frame |
| cmp_valid | input | 1 | Completion report present |
| cmp_cookie | input | 16 | Cookie carried by the completion |
| cmp_last | input | 1 | Completion closes a two-slot frame |
| cmp_done | output | 1 | Completion accepted and slots freed |
| cmp_order_err | output | 1 | Completion did not name the oldest slot |
| cmp_bad_cookie | output | 1 | Cookie names no ring or slot |
| ring_stopped | output | NUM_RINGS | Per-ring stopped level |
| ring_wake | output | NUM_RINGS | Per-ring one-cycle wake pulse |
| hwm_ring | input | 3 | Ring selected for high-water readout |
| hwm_level | output | $clog2(SLOTS+1) | High-water mark of the selected ring |

## Verification
The checker assumes that `alloc_ring` and `cmp_cookie` are stable in any cycle where their strobes are high. It also assumes that a completion arriving in the same cycle as an allocation is acceptable, but the stop and wake properties are phrased only for a single-event view of each ring. The bench drives each request or completion for exactly one clock and never overlaps an allocation with a completion. That keeps every result attributable to one event. Out-of-range ring ids and malformed cookies are driven on purpose to exercise the refusal paths.

// File: rtl/txs_pkg.sv
package txs_pkg;
    localparam int COOKIE_W   = 16;
    localparam int RING_ID_W  = 3;
    localparam int SLOT_FLD_W = 12;
    localparam int MAX_RINGS  = 6;
    localparam logic [3:0] PREFIX_BASE = 4'hA;
endpackage

// File: rtl/txs_cookie_codec.sv
module txs_cookie_codec
    import txs_pkg::*;
#(
    parameter int NUM_RINGS = 6,
    parameter int SLOTS     = 128,
    localparam int SLOT_W   = $clog2(SLOTS)
) (
    input  logic [RING_ID_W-1:0] enc_ring,
    input  logic [SLOT_W-1:0]    enc_slot,
    output logic [COOKIE_W-1:0]  enc_cookie,
    input  logic [COOKIE_W-1:0]  dec_cookie,
    output logic [RING_ID_W-1:0] dec_ring,
    output logic [SLOT_W-1:0]    dec_slot,
    output logic                 dec_ok
);
    logic [3:0]            prefix;
    logic [3:0]            offset;
    logic [SLOT_FLD_W-1:0] slot_fld;

    always_comb begin
        enc_cookie = {PREFIX_BASE + {1'b0, enc_ring}, SLOT_FLD_W'(enc_slot)};
        prefix     = dec_cookie[15:12];
        slot_fld   = dec_cookie[SLOT_FLD_W-1:0];
        offset     = prefix - PREFIX_BASE;
        dec_ring   = offset[RING_ID_W-1:0];
        dec_slot   = slot_fld[SLOT_W-1:0];
        dec_ok     = (prefix >= PREFIX_BASE) && (offset < 4'(NUM_RINGS))
                     && (slot_fld < SLOT_FLD_W'(SLOTS));
    end
endmodule

// File: rtl/txs_ring_ctrl.sv
module txs_ring_ctrl #(
    parameter int SLOTS   = 128,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_go,
    input  logic              cmp_go,
    input  logic [SLOT_W-1:0] cmp_slot,
    input  logic              cmp_last,
    output logic              alloc_ok,
    output logic [SLOT_W-1:0] hdr_slot,
    output logic              order_ok,
    output logic              stopped,
    output logic              wake,
    output logic [CNT_W-1:0]  hwm
);
    localparam int SUM_W = $clog2(2 * SLOTS + 2);

    typedef struct packed {
        logic [SLOT_W-1:0] cur;
        logic [CNT_W-1:0]  used;
        logic              stopped;
        logic              wake;
        logic [CNT_W-1:0]  hwm;
    } ring_st_t;

    ring_st_t st_d, st_q;

    logic [SLOT_W-1:0] pay_slot_d;
    logic [SLOT_W-1:0] oldest_d;
    logic [SUM_W-1:0]  sum_d;
    logic [CNT_W-1:0]  free_d, need_d, used_nx_d;

    function automatic logic [SLOT_W-1:0] step(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + 1'b1;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.wake  = 1'b0;
        free_d     = CNT_W'(SLOTS) - st_q.used;
        hdr_slot   = step(st_q.cur);
        pay_slot_d = step(hdr_slot);
        // oldest used slot: cur - used + 1, wrapped into [0, SLOTS)
        sum_d = SUM_W'(st_q.cur) + SUM_W'(SLOTS) + SUM_W'(1) - SUM_W'(st_q.used);
        if (sum_d >= SUM_W'(SLOTS)) sum_d = sum_d - SUM_W'(SLOTS);
        if (sum_d >= SUM_W'(SLOTS)) sum_d = sum_d - SUM_W'(SLOTS);
        oldest_d = sum_d[SLOT_W-1:0];
        need_d   = cmp_last ? CNT_W'(2) : CNT_W'(1);
        alloc_ok = alloc_go && !st_q.stopped && (free_d >= CNT_W'(2));
        order_ok = cmp_go && (st_q.used >= need_d) && (cmp_slot == oldest_d);
        used_nx_d = st_q.used;
        if (alloc_ok) begin
            st_d.cur  = pay_slot_d;
            used_nx_d = used_nx_d + CNT_W'(2);
        end
        if (order_ok) used_nx_d = used_nx_d - need_d;
        st_d.used = used_nx_d;
        if (used_nx_d > st_q.hwm) st_d.hwm = used_nx_d;
        if (alloc_ok && ((CNT_W'(SLOTS) - used_nx_d) < CNT_W'(2))) begin
            st_d.stopped = 1'b1;
        end else if (order_ok && st_q.stopped) begin
            st_d.stopped = 1'b0;
            st_d.wake    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cur     <= SLOT_W'(SLOTS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign stopped = st_q.stopped;
    assign wake    = st_q.wake;
    assign hwm     = st_q.hwm;
endmodule

// File: rtl/txs_slot_alloc.sv
module txs_slot_alloc
    import txs_pkg::*;
#(
    parameter int NUM_RINGS = 6,
    parameter int SLOTS     = 128,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int CNT_W    = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req,
    input  logic [RING_ID_W-1:0] alloc_ring,
    output logic                 alloc_ack,
    output logic                 alloc_err,
    output logic [SLOT_W-1:0]    alloc_slot,
    output logic [COOKIE_W-1:0]  alloc_cookie,
    input  logic                 cmp_valid,
    input  logic [COOKIE_W-1:0]  cmp_cookie,
    input  logic                 cmp_last,
    output logic                 cmp_done,
    output logic                 cmp_order_err,
    output logic                 cmp_bad_cookie,
    output logic [NUM_RINGS-1:0] ring_stopped,
    output logic [NUM_RINGS-1:0] ring_wake,
    input  logic [RING_ID_W-1:0] hwm_ring,
    output logic [CNT_W-1:0]     hwm_level
);
    typedef struct packed {
        logic                ack;
        logic                err;
        logic [SLOT_W-1:0]   slot;
        logic [COOKIE_W-1:0] cookie;
        logic                done;
        logic                order_err;
        logic                bad;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [NUM_RINGS-1:0] alloc_go, cmp_go, alloc_ok, order_ok;
    logic [SLOT_W-1:0]    hdr_slot [NUM_RINGS];
    logic [CNT_W-1:0]     hwm_arr  [NUM_RINGS];
    logic [SLOT_W-1:0]    sel_slot;
    logic [COOKIE_W-1:0]  enc_cookie;
    logic [RING_ID_W-1:0] dec_ring;
    logic [SLOT_W-1:0]    dec_slot;
    logic                 dec_ok;

    txs_cookie_codec #(.NUM_RINGS(NUM_RINGS), .SLOTS(SLOTS)) u_codec (
        .enc_ring  (alloc_ring),
        .enc_slot  (sel_slot),
        .enc_cookie(enc_cookie),
        .dec_cookie(cmp_cookie),
        .dec_ring  (dec_ring),
        .dec_slot  (dec_slot),
        .dec_ok    (dec_ok)
    );

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        assign alloc_go[r] = alloc_req && (alloc_ring == RING_ID_W'(r));
        assign cmp_go[r]   = cmp_valid && dec_ok && (dec_ring == RING_ID_W'(r));
        txs_ring_ctrl #(.SLOTS(SLOTS)) u_ring (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc_go(alloc_go[r]),
            .cmp_go  (cmp_go[r]),
            .cmp_slot(dec_slot),
            .cmp_last(cmp_last),
            .alloc_ok(alloc_ok[r]),
            .hdr_slot(hdr_slot[r]),
            .order_ok(order_ok[r]),
            .stopped (ring_stopped[r]),
            .wake    (ring_wake[r]),
            .hwm     (hwm_arr[r])
        );
    end

    always_comb begin
        sel_slot  = '0;
        hwm_level = '0;
        for (int r = 0; r < NUM_RINGS; r++) begin
            if (alloc_ring == RING_ID_W'(r)) sel_slot  = hdr_slot[r];
            if (hwm_ring == RING_ID_W'(r))   hwm_level = hwm_arr[r];
        end
        rsp_d           = '0;
        rsp_d.ack       = |alloc_ok;
        rsp_d.err       = alloc_req && !(|alloc_ok);
        rsp_d.slot      = (|alloc_ok) ? sel_slot : '0;
        rsp_d.cookie    = (|alloc_ok) ? enc_cookie : '0;
        rsp_d.done      = |order_ok;
        rsp_d.order_err = cmp_valid && dec_ok && !(|order_ok);
        rsp_d.bad       = cmp_valid && !dec_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign alloc_ack      = rsp_q.ack;
    assign alloc_err      = rsp_q.err;
    assign alloc_slot     = rsp_q.slot;
    assign alloc_cookie   = rsp_q.cookie;
    assign cmp_done       = rsp_q.done;
    assign cmp_order_err  = rsp_q.order_err;
    assign cmp_bad_cookie = rsp_q.bad;
endmodule

// File: rtl/txs_alloc_checker.sv
module txs_alloc_checker #(
    parameter int NUM_RINGS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_req,
    input logic [2:0]           alloc_ring,
    input logic                 alloc_ack,
    input logic                 alloc_err,
    input logic [15:0]          alloc_cookie,
    input logic                 cmp_valid,
    input logic [15:0]          cmp_cookie,
    input logic                 cmp_done,
    input logic                 cmp_order_err,
    input logic                 cmp_bad_cookie,
    input logic [NUM_RINGS-1:0] ring_stopped,
    input logic [NUM_RINGS-1:0] ring_wake
);
    logic [7:0] stop_ext;
    assign stop_ext = 8'(ring_stopped);

    assert_cookie_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ack |-> (alloc_cookie != 16'h0) && (alloc_cookie[15:12] >= 4'hA));

    assert_single_alloc_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_ack && alloc_err));

    assert_refuse_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && stop_ext[alloc_ring]) |=> (alloc_err && !alloc_ack));

    assert_refuse_bad_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && (alloc_ring >= 3'(NUM_RINGS))) |=> alloc_err);

    assert_cmp_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cmp_done, cmp_order_err, cmp_bad_cookie}) <= 1);

    assert_low_prefix_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && (cmp_cookie[15:12] < 4'hA)) |=> cmp_bad_cookie);

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_wake
        assert_wake_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ring_wake[r] |-> (!ring_stopped[r] && $past(ring_stopped[r]) && cmp_done));
    end
endmodule

bind txs_slot_alloc txs_alloc_checker #(.NUM_RINGS(NUM_RINGS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_req     (alloc_req),
    .alloc_ring    (alloc_ring),
    .alloc_ack     (alloc_ack),
    .alloc_err     (alloc_err),
    .alloc_cookie  (alloc_cookie),
    .cmp_valid     (cmp_valid),
    .cmp_cookie    (cmp_cookie),
    .cmp_done      (cmp_done),
    .cmp_order_err (cmp_order_err),
    .cmp_bad_cookie(cmp_bad_cookie),
    .ring_stopped  (ring_stopped),
    .ring_wake     (ring_wake)
);

// File: tb/txs_slot_alloc_test.sv
module txs_slot_alloc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [2:0]  alloc_ring = '0;
    logic        alloc_ack, alloc_err;
    logic [6:0]  alloc_slot;
    logic [15:0] alloc_cookie;
    logic        cmp_valid = 1'b0;
    logic [15:0] cmp_cookie = '0;
    logic        cmp_last = 1'b0;
    logic        cmp_done, cmp_order_err, cmp_bad_cookie;
    logic [5:0]  ring_stopped, ring_wake;
    logic [2:0]  hwm_ring = '0;
    logic [7:0]  hwm_level;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    txs_slot_alloc uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_ring(alloc_ring),
        .alloc_ack(alloc_ack), .alloc_err(alloc_err),
        .alloc_slot(alloc_slot), .alloc_cookie(alloc_cookie),
        .cmp_valid(cmp_valid), .cmp_cookie(cmp_cookie), .cmp_last(cmp_last),
        .cmp_done(cmp_done), .cmp_order_err(cmp_order_err),
        .cmp_bad_cookie(cmp_bad_cookie),
        .ring_stopped(ring_stopped), .ring_wake(ring_wake),
        .hwm_ring(hwm_ring), .hwm_level(hwm_level)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one request for one clock; response sampled at the following negedge
    task automatic do_alloc(input logic [2:0] ring, input bit exp_ack,
                            input logic [15:0] exp_cookie, input string tag);
        @(negedge clk);
        alloc_req  = 1'b1;
        alloc_ring = ring;
        @(negedge clk);
        alloc_req = 1'b0;
        chk(alloc_ack == exp_ack && alloc_err == !exp_ack, {tag, " ack/err"},
            {alloc_ack, alloc_err}, {exp_ack, !exp_ack});
        if (exp_ack) begin
            chk(alloc_cookie == exp_cookie, {tag, " cookie"}, alloc_cookie, exp_cookie);
            chk(alloc_slot == exp_cookie[6:0], {tag, " slot"}, alloc_slot, exp_cookie[6:0]);
        end
    endtask

    // kind: 0 done, 1 out of order, 2 bad cookie
    task automatic do_cmp(input logic [15:0] cookie, input bit last, input int kind,
                          input logic [5:0] exp_wake, input string tag);
        @(negedge clk);
        cmp_valid  = 1'b1;
        cmp_cookie = cookie;
        cmp_last   = last;
        @(negedge clk);
        cmp_valid = 1'b0;
        chk({cmp_done, cmp_order_err, cmp_bad_cookie} == 3'b100 >> kind, tag,
            {cmp_done, cmp_order_err, cmp_bad_cookie}, 3'b100 >> kind);
        chk(ring_wake == exp_wake, {tag, " wake"}, ring_wake, exp_wake);
        @(negedge clk);
        chk(ring_wake == 6'b0, {tag, " wake pulse width"}, ring_wake, 0);
    endtask

    task automatic chk_hwm(input logic [2:0] ring, input int exp, input string tag);
        @(negedge clk);
        hwm_ring = ring;
        #1;
        chk(hwm_level == 8'(exp), tag, hwm_level, exp);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ring_stopped == 6'b0, "R1 stopped", ring_stopped, 0);
        chk({alloc_ack, alloc_err, cmp_done, cmp_order_err, cmp_bad_cookie} == 5'b0,
            "R1 responses", {alloc_ack, alloc_err, cmp_done, cmp_order_err, cmp_bad_cookie}, 0);
        chk(ring_wake == 6'b0, "R1 wake", ring_wake, 0);
        chk_hwm(3'd0, 0, "R1 hwm");
    endtask

    task automatic t_basic_alloc;
        do_alloc(3'd0, 1'b1, 16'hA000, "R3 first frame");
        do_alloc(3'd0, 1'b1, 16'hA002, "R2 second frame");
        do_alloc(3'd5, 1'b1, 16'hF000, "R11 ring5 independent");
        do_alloc(3'd6, 1'b0, 16'h0, "R5 ring id 6");
        do_alloc(3'd7, 1'b0, 16'h0, "R5 ring id 7");
        chk_hwm(3'd0, 4, "R10 ring0 hwm");
        chk_hwm(3'd5, 2, "R10 ring5 hwm");
        chk_hwm(3'd2, 0, "R11 ring2 untouched");
        chk_hwm(3'd6, 0, "R10 unconfigured id");
    endtask

    task automatic t_completion_order;
        do_cmp(16'hA002, 1'b1, 1, 6'b0, "R6 skip oldest");
        do_cmp(16'hA000, 1'b1, 0, 6'b0, "R7 free frame");
        do_cmp(16'hA002, 1'b0, 0, 6'b0, "R7 free one");
        do_cmp(16'hA003, 1'b1, 1, 6'b0, "R7 need exceeds used");
        do_cmp(16'hA003, 1'b0, 0, 6'b0, "R7 free last slot");
        do_cmp(16'hA004, 1'b0, 1, 6'b0, "R7 empty ring");
        do_cmp(16'hF000, 1'b1, 0, 6'b0, "R11 ring5 completion");
        chk_hwm(3'd0, 4, "R10 hwm holds after frees");
    endtask

    task automatic t_bad_cookie;
        do_cmp(16'h1000, 1'b1, 2, 6'b0, "R9 low prefix");
        do_cmp(16'h0000, 1'b1, 2, 6'b0, "R9 zero cookie");
        do_cmp(16'hA080, 1'b1, 2, 6'b0, "R9 slot out of range");
        do_cmp(16'h9004, 1'b0, 2, 6'b0, "R9 prefix 9");
        // ring0 state untouched: next frame continues at slot 4
        do_alloc(3'd0, 1'b1, 16'hA004, "R9 state kept");
        do_cmp(16'hA004, 1'b1, 0, 6'b0, "R9 state kept completion");
    endtask

    task automatic t_fill_and_wake;
        for (int i = 0; i < 64; i++) begin
            do_alloc(3'd1, 1'b1, 16'hB000 | 16'(2 * i), "R3 fill ring1");
            if (i == 62) chk(ring_stopped[1] == 1'b0, "R4 not yet stopped", ring_stopped[1], 0);
        end
        chk(ring_stopped == 6'b000010, "R4 stopped when full", ring_stopped, 6'b000010);
        do_alloc(3'd1, 1'b0, 16'h0, "R5 full ring refused");
        chk_hwm(3'd1, 128, "R10 ring1 hwm full");
        do_cmp(16'hB000, 1'b1, 0, 6'b000010, "R8 wake on completion");
        chk(ring_stopped == 6'b0, "R8 stop cleared", ring_stopped, 0);
        do_alloc(3'd1, 1'b1, 16'hB000, "R3 wrap to slot 0");
        chk(ring_stopped[1] == 1'b1, "R4 stopped again", ring_stopped[1], 1);
        do_alloc(3'd2, 1'b1, 16'hC000, "R11 ring2 unaffected");
    endtask

    initial begin
        t_reset();
        t_basic_alloc();
        t_completion_order();
        t_bad_cookie();
        t_fill_and_wake();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule